// File: doc/BRIEF.md
# Configuration Transaction Command Controller

This block runs single configuration transactions against a small set of board-level value tables: six motherboard oscillator settings, a parameterised set of daughterboard oscillator settings, and voltage readings from the daughterboard and the motherboard. Software first loads a 32-bit data word, then writes a control word. The control word carries a launch bit, a direction bit and five addressing fields. The launch bit clears the status register. One cycle later the engine decodes the fields, checks the target, and does the access. It then sets a done bit, and an error bit if the command was refused.

A read that succeeds puts its value in the data register. A write that succeeds updates the selected oscillator entry from the data register. Two system commands, shutdown and reboot, each raise a one-cycle request pulse on a dedicated output. The whole register group is live only when the board-type input equals a parameterised value. On any other board type the three registers read as zero and ignore writes.

Top module: `cfgx_xact_ctrl`

## Requirements
- R1: After reset the data, control and status registers read zero. The motherboard oscillator entries 0 to 5 hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Daughterboard oscillator entries hold their parameter values.
- R2: The register offsets are data 0xA0, control 0xA4 and status 0xA8. Control fields are: bit 31 launch, bit 30 direction (1 write, 0 read), bits 29:26 link index, bits 25:20 function, bits 17:16 site, bits 15:12 slot, bits 11:0 unit. Bits 31 and 19:18 of the control register always read zero. All other control bits read back as written.
- R3: A control write with bit 31 set clears the status register (bit 0 done, bit 1 error) at that clock edge. At the next edge the engine sets done to 1 and sets the error bit to the command's outcome.
- R4: A command fails when the link index is not 0, or the slot is not 0, or the site is neither 0 (motherboard) nor 1 (daughterboard).
- R5: Function 1 (oscillator) reads or writes motherboard entry [unit] when the site is 0 and the unit is below 6. It reads or writes daughterboard entry [unit] when the site is 1 and the unit is below the daughterboard oscillator count. Any other unit fails. Oscillator entries change only through successful oscillator writes.
- R6: Function 2 (voltage) is read-only. On site 1 it returns daughterboard reading [unit] for a unit below the sensor count. On site 0 it returns 3300000 for unit 0 only. A write and any other unit fail.
- R7: A write of function 8 (shutdown) or function 9 (reboot) on site 0 unit 0 succeeds. It drives shutdown_req or reboot_req high for exactly the one cycle after the execution edge. A read of these functions fails, and so does any other site or unit.
- R8: A write of function 7 (video source select) or function 11 (display mode) on site 0 unit 0 succeeds and has no other effect. A read of these functions fails. Every other function code fails.
- R9: A successful read loads its result into the data register. A failed command leaves the data register unchanged.
- R10: A write to the status register stores only bits 1:0 of the written value.
- R11: When board_type differs from the active board value (default 0x190), the three registers read zero, writes to them are ignored, and a launch does nothing.
- R12: Read data appears on bus_rdata in the cycle after bus_ren is sampled. Offsets other than the three registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| board_type | input | 12 | Board type code; the registers are live only on the active value |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
On every cycle the assertions check these properties:
- The control register's read-back has bits 31 and 19:18 clear.
- A launch clears the status and is followed by done.
- A non-zero link index always ends in an error.
- The request pulses only follow an executing command.
- An inactive board returns zero.
- The oscillator tables hold still unless a table write is enabled.

Only the bench scenarios can show the rest, because they need a model of the tables:
- the exact values returned for each site, unit and function;
- that writes persist and read back later;
- that failed reads leave the data register untouched;
- that ignored writes on an inactive board leave earlier contents in place.

// File: rtl/cfgx_pkg.sv
`timescale 1ns/1ps
package cfgx_pkg;

  localparam int MB_CLK_N = 6;

  localparam logic [5:0] FN_OSC    = 6'd1;
  localparam logic [5:0] FN_VOLT   = 6'd2;
  localparam logic [5:0] FN_VIDSEL = 6'd7;
  localparam logic [5:0] FN_SHUT   = 6'd8;
  localparam logic [5:0] FN_REBOOT = 6'd9;
  localparam logic [5:0] FN_DISP   = 6'd11;

  localparam logic [1:0] SITE_MB = 2'd0;
  localparam logic [1:0] SITE_DB = 2'd1;

  // Control word layout; the field positions are decoded by the engine.
  typedef struct packed {
    logic        launch;
    logic        wr;
    logic [3:0]  link;
    logic [5:0]  fn;
    logic [1:0]  rsvd;
    logic [1:0]  site;
    logic [3:0]  slot;
    logic [11:0] unit;
  } ctrl_t;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_MB_CLK,
    TGT_DB_CLK,
    TGT_MB_VOLT,
    TGT_DB_VOLT,
    TGT_SHUT,
    TGT_REBOOT,
    TGT_NOP
  } tgt_e;

  function automatic logic [31:0] mb_clk_reset(input int idx);
    if (idx == 0)      return 32'd50000000;
    else if (idx == 1) return 32'd23750000;
    else               return 32'd24000000;
  endfunction

endpackage

// File: rtl/cfgx_decode.sv
`timescale 1ns/1ps
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int DB_CLK_N  = 3,
  parameter int DB_VOLT_N = 2
) (
  input  ctrl_t cmd,
  output tgt_e  tgt
);

  logic is_mb, is_db, route_ok, unit_zero;
  logic unused_fields;

  assign unused_fields = ^{cmd.launch, cmd.rsvd};
  assign is_mb     = (cmd.site == SITE_MB);
  assign is_db     = (cmd.site == SITE_DB);
  assign route_ok  = (cmd.link == 4'd0) && (cmd.slot == 4'd0) && (is_mb || is_db);
  assign unit_zero = (cmd.unit == 12'd0);

  always_comb begin
    tgt = TGT_NONE;
    if (route_ok) begin
      case (cmd.fn)
        FN_OSC: begin
          if (is_mb && int'(cmd.unit) < MB_CLK_N)      tgt = TGT_MB_CLK;
          else if (is_db && int'(cmd.unit) < DB_CLK_N) tgt = TGT_DB_CLK;
        end
        FN_VOLT: begin
          if (!cmd.wr) begin
            if (is_db && int'(cmd.unit) < DB_VOLT_N) tgt = TGT_DB_VOLT;
            else if (is_mb && unit_zero)             tgt = TGT_MB_VOLT;
          end
        end
        FN_VIDSEL, FN_DISP: if (cmd.wr && is_mb && unit_zero) tgt = TGT_NOP;
        FN_SHUT:            if (cmd.wr && is_mb && unit_zero) tgt = TGT_SHUT;
        FN_REBOOT:          if (cmd.wr && is_mb && unit_zero) tgt = TGT_REBOOT;
        default:            tgt = TGT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cfgx_store.sv
`timescale 1ns/1ps
module cfgx_store
  import cfgx_pkg::*;
#(
  parameter int                      DB_CLK_N    = 3,
  parameter int                      DB_VOLT_N   = 2,
  parameter logic [DB_CLK_N*32-1:0]  DB_CLK_INIT = {32'd60000000, 32'd45000000, 32'd33000000},
  parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_VAL = {32'd1800000, 32'd1000000},
  parameter logic [31:0]             MB_VOLT_UV  = 32'd3300000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  tgt_e        tgt,
  input  logic [11:0] unit,
  input  logic [31:0] wdata,
  output logic [31:0] rd_val
);

  logic [MB_CLK_N-1:0][31:0] mb_q;
  logic [DB_CLK_N-1:0][31:0] db_q;

  for (genvar g = 0; g < MB_CLK_N; g++) begin : g_mb
    always_ff @(posedge clk) begin
      if (rst)
        mb_q[g] <= mb_clk_reset(g);
      else if (wr_en && tgt == TGT_MB_CLK && int'(unit) == g)
        mb_q[g] <= wdata;
    end
  end

  for (genvar g = 0; g < DB_CLK_N; g++) begin : g_db
    always_ff @(posedge clk) begin
      if (rst)
        db_q[g] <= DB_CLK_INIT[g*32 +: 32];
      else if (wr_en && tgt == TGT_DB_CLK && int'(unit) == g)
        db_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_val = 32'd0;
    case (tgt)
      TGT_MB_CLK:
        for (int k = 0; k < MB_CLK_N; k++)
          if (int'(unit) == k) rd_val = mb_q[k];
      TGT_DB_CLK:
        for (int k = 0; k < DB_CLK_N; k++)
          if (int'(unit) == k) rd_val = db_q[k];
      TGT_DB_VOLT:
        for (int k = 0; k < DB_VOLT_N; k++)
          if (int'(unit) == k) rd_val = DB_VOLT_VAL[k*32 +: 32];
      TGT_MB_VOLT: rd_val = MB_VOLT_UV;
      default:     rd_val = 32'd0;
    endcase
  end

  // R5: tables change only on an enabled write
  assert_clk_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(mb_q) && $stable(db_q)));

endmodule

// File: rtl/cfgx_xact_ctrl.sv
`timescale 1ns/1ps
module cfgx_xact_ctrl
  import cfgx_pkg::*;
#(
  parameter int                      ADDR_W       = 8,
  parameter logic [11:0]             ACTIVE_BOARD = 12'h190,
  parameter int                      DB_CLK_N     = 3,
  parameter int                      DB_VOLT_N    = 2,
  parameter logic [DB_CLK_N*32-1:0]  DB_CLK_INIT  = {32'd60000000, 32'd45000000, 32'd33000000},
  parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_VAL  = {32'd1800000, 32'd1000000},
  parameter logic [31:0]             MB_VOLT_UV   = 32'd3300000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       board_type,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_ren,
  output logic [31:0]       bus_rdata,
  output logic              shutdown_req,
  output logic              reboot_req
);

  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'('hA0);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('hA4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('hA8);
  localparam logic [31:0]       CTRL_KEEP = 32'h7FF3FFFF;

  logic        active;
  ctrl_t       ctrl_q;
  logic [31:0] data_q;
  logic [1:0]  stat_q;
  logic        pend_q;
  tgt_e        tgt;
  logic [31:0] rd_val;
  logic        tbl_wr;
  logic [31:0] rd_mux;

  assign active = (board_type == ACTIVE_BOARD);
  assign tbl_wr = pend_q && ctrl_q.wr && (tgt != TGT_NONE);

  cfgx_decode #(
    .DB_CLK_N (DB_CLK_N),
    .DB_VOLT_N(DB_VOLT_N)
  ) u_decode (
    .cmd(ctrl_q),
    .tgt(tgt)
  );

  cfgx_store #(
    .DB_CLK_N   (DB_CLK_N),
    .DB_VOLT_N  (DB_VOLT_N),
    .DB_CLK_INIT(DB_CLK_INIT),
    .DB_VOLT_VAL(DB_VOLT_VAL),
    .MB_VOLT_UV (MB_VOLT_UV)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (tbl_wr),
    .tgt   (tgt),
    .unit  (ctrl_q.unit),
    .wdata (data_q),
    .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q       <= '0;
      data_q       <= '0;
      stat_q       <= '0;
      pend_q       <= 1'b0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      pend_q       <= 1'b0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
      if (bus_wen && active) begin
        case (bus_addr)
          OFS_DATA: data_q <= bus_wdata;
          OFS_CTRL: begin
            ctrl_q <= ctrl_t'(bus_wdata & CTRL_KEEP);
            if (bus_wdata[31]) begin
              pend_q <= 1'b1;
              stat_q <= 2'b00;
            end
          end
          OFS_STAT: stat_q <= bus_wdata[1:0];
          default: ;
        endcase
      end
      // the executing command takes priority over a same-cycle bus write
      if (pend_q) begin
        stat_q       <= {tgt == TGT_NONE, 1'b1};
        shutdown_req <= (tgt == TGT_SHUT);
        reboot_req   <= (tgt == TGT_REBOOT);
        if (!ctrl_q.wr && tgt != TGT_NONE) data_q <= rd_val;
      end
    end
  end

  always_comb begin
    rd_mux = 32'd0;
    if (active) begin
      case (bus_addr)
        OFS_DATA: rd_mux = data_q;
        OFS_CTRL: rd_mux = ctrl_q;
        OFS_STAT: rd_mux = {30'd0, stat_q};
        default:  rd_mux = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= 32'd0;
    else if (bus_ren) bus_rdata <= rd_mux;
  end

  // R2: launch and undefined bits never read back
  assert_ctrl_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && active && bus_addr == OFS_CTRL) |=> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

  // R3: a launch clears the status, then done follows
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && active && bus_addr == OFS_CTRL && bus_wdata[31] && !pend_q) |=> (stat_q == 2'b00));

  assert_done_follows_R3: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> stat_q[0]);

  // R4: a non-zero link index always ends in an error
  assert_bad_link_R4: assert property (@(posedge clk) disable iff (rst)
    (pend_q && ctrl_q.link != 4'd0) |=> (stat_q == 2'b11));

  // R7: request pulses only follow an executing command, never both at once
  assert_pulse_src_R7: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req || reboot_req) |-> $past(pend_q));

  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(shutdown_req && reboot_req));

  // R11: an inactive board reads zero
  assert_idle_board_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && !active) |=> (bus_rdata == 32'd0));

endmodule

// File: tb/test_cfgx_xact_ctrl.sv
`timescale 1ns/1ps
module test_cfgx_xact_ctrl;

  localparam int          DBC  = 3;
  localparam int          DBV  = 2;
  localparam logic [31:0] DBC0 = 32'd33000000;
  localparam logic [31:0] DBC1 = 32'd45000000;
  localparam logic [31:0] DBC2 = 32'd60000000;
  localparam logic [31:0] DBV0 = 32'd1000000;
  localparam logic [31:0] DBV1 = 32'd1800000;
  localparam logic [7:0]  A_DATA = 8'hA0;
  localparam logic [7:0]  A_CTRL = 8'hA4;
  localparam logic [7:0]  A_STAT = 8'hA8;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] board_type;
  logic [7:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic        bus_ren;
  logic [31:0] bus_rdata;
  logic        shutdown_req;
  logic        reboot_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_mb [6];
  logic [31:0] m_db [DBC];

  always #2 clk = ~clk;

  cfgx_xact_ctrl #(
    .ADDR_W(8), .ACTIVE_BOARD(12'h190), .DB_CLK_N(DBC), .DB_VOLT_N(DBV),
    .DB_CLK_INIT({DBC2, DBC1, DBC0}), .DB_VOLT_VAL({DBV1, DBV0}),
    .MB_VOLT_UV(32'd3300000)
  ) i_cfgx_xact_ctrl (
    .clk(clk), .rst(rst), .board_type(board_type), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_ren(bus_ren),
    .bus_rdata(bus_rdata), .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  // kinds: 0 fail, 1 mb clk, 2 db clk, 3 mb volt, 4 db volt, 5 shut, 6 reboot, 7 accepted no-op
  function automatic int classify(input bit wr, input int link, input int fn,
                                  input int site, input int slot, input int unit);
    if (link != 0 || slot != 0 || site > 1) return 0;
    case (fn)
      1: begin
        if (site == 0 && unit < 6)   return 1;
        if (site == 1 && unit < DBC) return 2;
        return 0;
      end
      2: begin
        if (wr) return 0;
        if (site == 1 && unit < DBV) return 4;
        if (site == 0 && unit == 0)  return 3;
        return 0;
      end
      7, 11: return (wr && site == 0 && unit == 0) ? 7 : 0;
      8:     return (wr && site == 0 && unit == 0) ? 5 : 0;
      9:     return (wr && site == 0 && unit == 0) ? 6 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int kind, input int unit);
    case (kind)
      1: return m_mb[unit];
      2: return m_db[unit];
      3: return 32'd3300000;
      4: return (unit == 0) ? DBV0 : DBV1;
      default: return 32'd0;
    endcase
  endfunction

  task automatic run_cmd(input bit wr, input int link, input int fn, input int site,
                         input int slot, input int unit, input logic [31:0] dval,
                         input logic [1:0] rsv);
    logic [31:0] word, got, exp_data;
    int kind;
    string tag;
    kind = classify(wr, link, fn, site, slot, unit);
    if (link != 0 || slot != 0 || site > 1) tag = "R4";
    else if (fn == 1) tag = "R5";
    else if (fn == 2) tag = "R6";
    else if (fn == 8 || fn == 9) tag = "R7";
    else tag = "R8";
    word = {1'b1, wr, link[3:0], fn[5:0], rsv, site[1:0], slot[3:0], unit[11:0]};
    bus_write(A_DATA, dval);
    bus_write(A_CTRL, word);
    @(negedge clk);
    check({tag, " shutdown pulse"}, {31'd0, shutdown_req}, {31'd0, kind == 5});
    check({tag, " reboot pulse"}, {31'd0, reboot_req}, {31'd0, kind == 6});
    @(negedge clk);
    check({tag, " pulse width"}, {30'd0, shutdown_req, reboot_req}, 32'd0);
    bus_read(A_STAT, got);
    check({tag, " status"}, got, {30'd0, kind == 0, 1'b1});
    exp_data = (!wr && kind != 0) ? model_read(kind, unit) : dval;
    bus_read(A_DATA, got);
    check("R9 data register", got, exp_data);
    bus_read(A_CTRL, got);
    check("R2 control readback", got, word & 32'h7FF3FFFF);
    if (wr && kind == 1) m_mb[unit] = dval;
    if (wr && kind == 2) m_db[unit] = dval;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, keep_data, keep_stat;
    int fn_pick [8];
    void'($urandom(32'd20240611));
    fn_pick = '{1, 1, 2, 7, 8, 9, 11, 0};
    m_mb = '{32'd50000000, 32'd23750000, 32'd24000000, 32'd24000000, 32'd24000000, 32'd24000000};
    m_db = '{DBC0, DBC1, DBC2};
    rst = 1'b1; board_type = 12'h190; bus_addr = '0; bus_wen = 0; bus_wdata = '0; bus_ren = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: register reset state
    bus_read(A_DATA, got); check("R1 data reset", got, 32'd0);
    bus_read(A_CTRL, got); check("R1 ctrl reset", got, 32'd0);
    bus_read(A_STAT, got); check("R1 stat reset", got, 32'd0);
    // R1: table reset values read through commands
    for (int u = 0; u < 6; u++) run_cmd(1'b0, 0, 1, 0, 0, u, 32'hDEAD0000, 2'b00);
    for (int u = 0; u < DBC; u++) run_cmd(1'b0, 0, 1, 1, 0, u, 32'hDEAD0001, 2'b00);

    // R10: status write keeps bits 1:0
    bus_write(A_STAT, 32'hFFFFFFFF); bus_read(A_STAT, got); check("R10 status store", got, 32'd3);
    bus_write(A_STAT, 32'hFFFFFFFE); bus_read(A_STAT, got); check("R10 status store", got, 32'd2);

    // R3: launch clears status before done appears
    bus_write(A_STAT, 32'd3);
    bus_write(A_CTRL, 32'h80100003);
    bus_read(A_STAT, got); check("R3 cleared at launch", got, 32'd0);
    bus_read(A_STAT, got); check("R3 done set", got, 32'd1);
    bus_read(A_DATA, got); check("R9 read loads data", got, 32'd24000000);

    // R12: unmapped offsets read zero
    bus_write(8'h00, 32'h12345678);
    bus_read(8'h00, got); check("R12 unmapped", got, 32'd0);
    bus_read(8'h9C, got); check("R12 unmapped", got, 32'd0);

    // directed corners
    run_cmd(1'b1, 0, 1, 1, 0, DBC, 32'h11111111, 2'b00);  // R5 out of range
    run_cmd(1'b1, 0, 1, 0, 0, 6, 32'h22222222, 2'b11);    // R5 out of range
    run_cmd(1'b1, 0, 1, 0, 0, 5, 32'h0BADF00D, 2'b00);    // R5 write
    run_cmd(1'b0, 0, 1, 0, 0, 5, 32'h0, 2'b00);           // R5 readback
    run_cmd(1'b0, 0, 2, 0, 0, 0, 32'h0, 2'b00);           // R6 mb
    run_cmd(1'b0, 0, 2, 0, 0, 1, 32'h5, 2'b00);           // R6 bad unit
    run_cmd(1'b1, 0, 2, 1, 0, 0, 32'h6, 2'b00);           // R6 write fails
    run_cmd(1'b0, 0, 2, 1, 0, 1, 32'h7, 2'b00);           // R6 db
    run_cmd(1'b1, 0, 8, 0, 0, 0, 32'h8, 2'b00);           // R7 shutdown
    run_cmd(1'b1, 0, 9, 0, 0, 0, 32'h9, 2'b00);           // R7 reboot
    run_cmd(1'b0, 0, 8, 0, 0, 0, 32'hA, 2'b00);           // R7 read fails
    run_cmd(1'b1, 0, 9, 0, 0, 1, 32'hB, 2'b00);           // R7 bad unit
    run_cmd(1'b1, 0, 7, 0, 0, 0, 32'hC, 2'b00);           // R8 accepted
    run_cmd(1'b1, 0, 11, 0, 0, 0, 32'hD, 2'b00);          // R8 accepted
    run_cmd(1'b0, 0, 11, 0, 0, 0, 32'hE, 2'b00);          // R8 read fails
    run_cmd(1'b1, 0, 3, 0, 0, 0, 32'hF, 2'b00);           // R8 unknown fn
    run_cmd(1'b0, 1, 1, 0, 0, 0, 32'h10, 2'b00);          // R4 link
    run_cmd(1'b0, 0, 1, 0, 2, 0, 32'h11, 2'b00);          // R4 slot
    run_cmd(1'b0, 0, 1, 2, 0, 0, 32'h12, 2'b00);          // R4 site

    // random mix
    for (int n = 0; n < 300; n++) begin
      int link, slot, site, fn, unit;
      bit wr;
      link = ($urandom % 8 == 0) ? 1 + ($urandom % 15) : 0;
      slot = ($urandom % 8 == 0) ? 1 + ($urandom % 15) : 0;
      site = ($urandom % 4 == 0) ? ($urandom % 4) : ($urandom % 2);
      fn   = fn_pick[$urandom % 8];
      if (fn == 0) fn = $urandom % 64;
      unit = ($urandom % 10 == 0) ? ($urandom % 4096) : ($urandom % 8);
      wr   = 1'($urandom % 2);
      run_cmd(wr, link, fn, site, slot, unit, $urandom, 2'($urandom % 4));
    end

    // R11: inactive board type
    bus_read(A_DATA, keep_data);
    bus_read(A_STAT, keep_stat);
    board_type = 12'h178;
    bus_read(A_DATA, got); check("R11 data reads zero", got, 32'd0);
    bus_read(A_CTRL, got); check("R11 ctrl reads zero", got, 32'd0);
    bus_read(A_STAT, got); check("R11 stat reads zero", got, 32'd0);
    bus_write(A_DATA, 32'hCAFEF00D);
    bus_write(A_STAT, 32'd0);
    bus_write(A_CTRL, 32'hC0800000);
    @(negedge clk);
    check("R11 no shutdown", {31'd0, shutdown_req}, 32'd0);
    @(negedge clk);
    board_type = 12'h190;
    bus_read(A_DATA, got); check("R11 data kept", got, keep_data);
    bus_read(A_STAT, got); check("R11 stat kept", got, keep_stat);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule